// File: doc/BRIEF.md
# Brownout-Qualified Power-On Reset Generator

This block turns supply-status information into the system reset. An analog comparator outside the block compares the supply against two thresholds. It reports the result as two logic-level "supply low" flags: one for the tighter (5 %) threshold and one for the looser (10 %) threshold. A strap input selects which of the two flags counts as a low supply. The flags are asynchronous to the block clock, so they pass through a two-flop synchronizer before any logic uses them.

Reset is held active from the block's own synchronous reset (power-up) and whenever the selected flag reports a low supply. It is released only when the supply has been good for an unbroken run of `QUAL_TICKS` millisecond ticks, 250 by default. Timing comes from a one-cycle `tick_ms` enable. Any dip, even a single sampled cycle, sends the block back and restarts qualification from zero. The reset is driven both active-high and active-low.

The controller is a four-state machine:
- `ST_BOOT` is entered on the block's own reset.
- `ST_LOW` means the supply is low.
- `ST_QUAL` means the supply is good and the tick count is running.
- `ST_RUN` means reset has been released.

Transitions:
- BOOT→LOW always.
- LOW→QUAL when the supply is good. LOW→RUN only if that same cycle completes qualification.
- QUAL→LOW on a dip.
- QUAL→RUN on the completing tick.
- RUN→LOW on a dip.
- Any state goes to BOOT on the block's reset.

Top module: `supply_reset_gen`

## Requirements
- R1: When the selected low flag goes high, `sys_rst` is 1 after the third rising clock edge that follows the flag change. The three edges are two synchronizer flops and the state register. Reset stays 1 for as long as the synchronized flag stays high.
- R2: `supply_low[0]` means "below the 5 % threshold" and `supply_low[1]` means "below the 10 % threshold". With `tol_sel`=0 only bit 0 is used, and with `tol_sel`=1 only bit 1 is used. The unselected bit has no effect on the outputs.
- R3: `sys_rst` falls only on the edge where the `QUAL_TICKS`-th `tick_ms` is seen while the synchronized supply has been good continuously. The ticks are counted from the edge after the supply became good.
- R4: Any cycle in which the synchronized selected flag is high clears the qualification count. After the supply returns, a full `QUAL_TICKS` ticks are again needed.
- R5: While `srst` is 1, `sys_rst` is 1 after the next edge. The synchronizer restarts from a "low" value, and release then needs a full qualification.
- R6: `sys_rst_n` is always the complement of `sys_rst`.
- R7: Without `tick_ms` pulses, qualification never completes, however long the supply stays good.
- R8: If a dip and the completing tick fall in the same cycle, the dip wins. Reset stays active and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| srst | input | 1 | Synchronous active-high reset of the block (power-up) |
| tick_ms | input | 1 | One-cycle 1 ms timing enable |
| tol_sel | input | 1 | Threshold choice: 0 = 5 % flag, 1 = 10 % flag |
| supply_low | input | 2 | Asynchronous comparator flags, bit 0 = below 5 % level, bit 1 = below 10 % level |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The two functions that can collide are the dip detection and the completion of qualification. A synchronized low flag and the tick that would reach `QUAL_TICKS` can arrive in the same cycle. The bench provokes this on purpose: it delivers `QUAL_TICKS-1` ticks one at a time, raises the flag, and after exactly two synchronizer edges pulses the tick. It then expects reset to stay active and to need a further full `QUAL_TICKS` ticks. The randomized phase also lets the two coincide by chance. There, every cycle is judged against a bench model built from the requirements.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_LOW  = 2'd1,
        ST_QUAL = 2'd2,
        ST_RUN  = 2'd3
    } por_state_e;

endpackage

// File: rtl/por_sync.sv
// Two-flop synchronizer per bit; reset value chosen by parameter.
module por_sync #(
    parameter int          WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             srst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (srst) begin
                meta_q <= RESET_VAL[b];
                stab_q <= RESET_VAL[b];
            end else begin
                meta_q <= d_async[b];
                stab_q <= meta_q;
            end
        end
        assign q_sync[b] = stab_q;
    end
endmodule

// File: rtl/por_tol_mux.sv
// Picks the flag that counts as "supply low".
module por_tol_mux #(
    parameter int LEVELS = 2,
    localparam int SEL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              low
);
    always_comb begin
        low = 1'b1;
        for (int i = 0; i < LEVELS; i++) begin
            if (sel == SEL_W'(i)) low = flags[i];
        end
    end
endmodule

// File: rtl/por_qual_counter.sv
// Counts ticks of good supply; flags the tick that would complete qualification.
module por_qual_counter #(
    parameter int QUAL_TICKS = 250,
    localparam int CNT_W = $clog2(QUAL_TICKS + 1)
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_TICKS - 1);

    assign at_last = (count == LAST);

    always_ff @(posedge clk) begin
        if (srst || clear) begin
            count <= '0;
        end else if (tick) begin
            count <= at_last ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
    parameter int QUAL_TICKS = 250,
    parameter int LEVELS     = 2
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              tick_ms,
    input  logic              tol_sel,
    input  logic [LEVELS-1:0] supply_low,
    output logic              sys_rst,
    output logic              sys_rst_n
);
    import por_pkg::*;

    localparam int CNT_W = $clog2(QUAL_TICKS + 1);
    localparam int SEL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [LEVELS-1:0] low_sync;
    logic              sel_low;
    logic              cnt_clear;
    logic              at_last;
    logic              qual_done;
    logic [CNT_W-1:0]  qual_cnt;
    por_state_e        state_q, state_d;

    por_sync #(.WIDTH(LEVELS), .RESET_VAL({LEVELS{1'b1}})) u_sync (
        .clk     (clk),
        .srst    (srst),
        .d_async (supply_low),
        .q_sync  (low_sync)
    );

    por_tol_mux #(.LEVELS(LEVELS)) u_mux (
        .flags (low_sync),
        .sel   (SEL_W'(tol_sel)),
        .low   (sel_low)
    );

    // Count only while not released and supply good.
    assign cnt_clear = sel_low || (state_q == ST_RUN) || (state_q == ST_BOOT);
    assign qual_done = tick_ms && at_last && !sel_low;

    por_qual_counter #(.QUAL_TICKS(QUAL_TICKS)) u_cnt (
        .clk     (clk),
        .srst    (srst),
        .clear   (cnt_clear),
        .tick    (tick_ms),
        .count   (qual_cnt),
        .at_last (at_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_LOW;
            ST_LOW: begin
                if (!sel_low) state_d = qual_done ? ST_RUN : ST_QUAL;
            end
            ST_QUAL: begin
                if (sel_low)        state_d = ST_LOW;
                else if (qual_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (sel_low) state_d = ST_LOW;
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (srst) state_q <= ST_BOOT;
        else      state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_RUN:  sys_rst = 1'b0;
            default: sys_rst = 1'b1;
        endcase
        sys_rst_n = ~sys_rst;
    end
endmodule

// File: rtl/por_reset_checker.sv
module por_reset_checker #(
    parameter int QUAL_TICKS = 250,
    parameter int CNT_W      = 8
) (
    input logic             clk,
    input logic             srst,
    input logic             tick_ms,
    input logic             sel_low,
    input logic [CNT_W-1:0] qual_cnt,
    input logic             sys_rst,
    input logic             sys_rst_n
);
    // R1: a synchronized low always leads to reset
    assert_low_forces_reset_R1: assert property (@(posedge clk) disable iff (srst)
        sel_low |=> sys_rst);

    // R3: release happens only on a completing tick
    assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (srst)
        $fell(sys_rst) |-> ($past(tick_ms) && $past(qual_cnt) == CNT_W'(QUAL_TICKS - 1)));

    // R4: a dip clears the qualification count
    assert_dip_clears_count_R4: assert property (@(posedge clk) disable iff (srst)
        sel_low |=> (qual_cnt == '0));

    // R5: own reset forces the output active
    assert_srst_forces_reset_R5: assert property (@(posedge clk)
        srst |=> sys_rst);

    // R7: without a tick the count never advances
    assert_no_tick_no_count_R7: assert property (@(posedge clk) disable iff (srst)
        !tick_ms |=> ($stable(qual_cnt) || qual_cnt == '0));

    // R8: dip coinciding with a tick keeps reset active
    assert_dip_beats_tick_R8: assert property (@(posedge clk) disable iff (srst)
        (sel_low && tick_ms) |=> (sys_rst && qual_cnt == '0));

    // R6: outputs complementary
    always @(negedge clk) begin
        if (!srst) begin
            assert_outputs_complement_R6: assert (sys_rst_n == ~sys_rst);
        end
    end
endmodule

bind supply_reset_gen por_reset_checker #(.QUAL_TICKS(QUAL_TICKS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .srst      (srst),
    .tick_ms   (tick_ms),
    .sel_low   (sel_low),
    .qual_cnt  (qual_cnt),
    .sys_rst   (sys_rst),
    .sys_rst_n (sys_rst_n)
);

// File: tb/sim_supply_reset_gen.sv
module sim_supply_reset_gen;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 250;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       tick_ms = 1'b0;
    logic       tol_sel = 1'b0;
    logic [1:0] supply_low = 2'b00;
    logic       sys_rst, sys_rst_n;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done_flag = 0;
    string cur_tag = "R5";

    // Reference model state
    logic [1:0] m_s1, m_s2;
    bit         m_rel;
    int         m_cnt;

    supply_reset_gen #(.QUAL_TICKS(N)) u0 (
        .clk(clk), .srst(srst), .tick_ms(tick_ms), .tol_sel(tol_sel),
        .supply_low(supply_low), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit model_low(logic [1:0] s, logic t);
        return t ? s[1] : s[0];
    endfunction

    // Model from the requirements: two sync stages, then release after N good ticks.
    always @(posedge clk) begin
        started <= 1'b1;
        if (srst) begin
            m_s1 <= 2'b11; m_s2 <= 2'b11; m_rel <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= supply_low;
            m_s2 <= m_s1;
            if (model_low(m_s2, tol_sel)) begin
                m_rel <= 0; m_cnt <= 0;
            end else if (!m_rel && tick_ms) begin
                if (m_cnt == N - 1) begin m_rel <= 1; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done_flag) begin
            chk(sys_rst == !m_rel, cur_tag, int'(sys_rst), int'(!m_rel));
            chk(sys_rst_n == ~sys_rst, "R6", int'(sys_rst_n), int'(~sys_rst));
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            pulse_tick();
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20517));
        // Reset state
        cyc(4);
        chk(sys_rst == 1'b1, "R5", int'(sys_rst), 1);
        srst = 1'b0;
        cyc(6);
        chk(sys_rst == 1'b1, "R5", int'(sys_rst), 1);

        // No ticks: never releases
        cur_tag = "R7";
        cyc(1500);
        chk(sys_rst == 1'b1, "R7", int'(sys_rst), 1);

        // Basic qualification: N-1 ticks not enough, Nth releases
        cur_tag = "R3";
        ticks(N - 1);
        chk(sys_rst == 1'b1, "R3", int'(sys_rst), 1);
        pulse_tick();
        chk(sys_rst == 1'b0, "R3", int'(sys_rst), 0);

        // Unselected flag ignored, selected flag asserts after three edges
        cur_tag = "R2";
        supply_low = 2'b10;
        cyc(6);
        chk(sys_rst == 1'b0, "R2", int'(sys_rst), 0);
        supply_low = 2'b00;
        cyc(3);
        cur_tag = "R1";
        supply_low = 2'b01;
        cyc(2);
        chk(sys_rst == 1'b0, "R1", int'(sys_rst), 0);
        cyc(1);
        chk(sys_rst == 1'b1, "R1", int'(sys_rst), 1);
        tol_sel = 1'b1;                 // bit 0 now unselected
        cur_tag = "R2";
        cyc(4);
        ticks(N);
        chk(sys_rst == 1'b0, "R2", int'(sys_rst), 0);
        supply_low = 2'b10;
        cyc(3);
        chk(sys_rst == 1'b1, "R2", int'(sys_rst), 1);
        supply_low = 2'b00;
        tol_sel = 1'b0;
        cyc(4);

        // Dip mid-qualification restarts count
        cur_tag = "R4";
        ticks(N / 2);
        supply_low = 2'b01;
        @(negedge clk);
        supply_low = 2'b00;
        cyc(4);
        ticks(N - 1);
        chk(sys_rst == 1'b1, "R4", int'(sys_rst), 1);
        pulse_tick();
        chk(sys_rst == 1'b0, "R4", int'(sys_rst), 0);

        // Dip coinciding with completing tick
        cur_tag = "R8";
        srst = 1'b1; cyc(2); srst = 1'b0; cyc(5);
        ticks(N - 1);
        supply_low = 2'b01;
        cyc(2);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
        supply_low = 2'b00;
        cyc(2);
        chk(sys_rst == 1'b1, "R8", int'(sys_rst), 1);
        cyc(4);
        ticks(N - 1);
        chk(sys_rst == 1'b1, "R8", int'(sys_rst), 1);
        pulse_tick();
        chk(sys_rst == 1'b0, "R8", int'(sys_rst), 0);

        // Own reset mid-run
        cur_tag = "R5";
        srst = 1'b1; @(negedge clk);
        chk(sys_rst == 1'b1, "R5", int'(sys_rst), 1);
        srst = 1'b0; cyc(4);

        // Constrained random phase
        cur_tag = "R1";
        for (int i = 0; i < 40000; i++) begin
            tick_ms = ($urandom % 3) == 0;
            if (($urandom % 1500) == 0) supply_low[0] = ~supply_low[0];
            if (($urandom % 1500) == 0) supply_low[1] = ~supply_low[1];
            if (($urandom % 4000) == 0) tol_sel = ~tol_sel;
            if (($urandom % 9000) == 0) srst = 1'b1; else srst = 1'b0;
            if (($urandom % 700) == 0) supply_low = supply_low | 2'b11;
            if (($urandom % 2) == 0 && supply_low == 2'b11 && ($urandom % 50) == 0) supply_low = 2'b00;
            @(negedge clk);
        end
        srst = 1'b0; tick_ms = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule